// File: doc/BRIEF.md
# Output Fault Status Recorder

This block records which of a driver's sixteen outputs shows an open or a shorted load, and hands that record to the serial chain so a host can read it back. A two-bit detection-mode field, taken from the device's configuration word, arms the check. Sixteen comparator flags arrive as digital inputs, one per output. Each flag says whether that output node sits above the detection threshold. The analog comparison itself happens outside the block.

The serial side runs on the system clock. Two one-cycle pulses mark the serial clock edges: the rising pulse shifts the input bit into the word, and the falling pulse moves the word's top bit onto the serial output. A strobe pulse ends each command word. If the strobe finds the read-status command value `0x003C` in the shift word, the block replaces the word with the fault status. Further serial clocks then shift the status out with output 15 first. Several devices can be chained by wiring each serial output to the next device's serial input. The device at the far end of the chain delivers its status first.

Top module: `fault_status_capture`

## Requirements
- R1: After reset, the shift word and the serial output are all zero, so a readout with no capture returns zeros.
- R2: On a rising-edge pulse with no capture, the shift word moves one place toward bit 15 and takes the serial input into bit 0.
- R3: The serial output changes only on a falling-edge pulse. At that pulse it takes bit 15 of the shift word, and it holds its value at all other times.
- R4: A strobe pulse captures the status only while the shift word equals `0x003C`. Capture takes precedence over a rising-edge pulse in the same cycle.
- R5: With the mode field at `2'b01` (open check) and every output off, status bit n is 1 exactly when the flag for output n is 0, meaning the node is below the threshold.
- R6: With the mode field at `2'b10` (short check) and every output off, status bit n is 1 exactly when the flag for output n is 0.
- R7: With the mode field at `2'b00` or `2'b11`, the captured status word is all zeros.
- R8: If any output is on when capture happens, the captured status word is all zeros.
- R9: A strobe pulse when the shift word holds any value other than `0x003C` leaves the shift word unchanged.
- R10: In a chain, the status read out from the final device comes first, MSB first, followed by the status of the device upstream of it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_rise | input | 1 | One-cycle pulse marking a serial clock rising edge |
| sclk_fall | input | 1 | One-cycle pulse marking a serial clock falling edge |
| ser_in | input | 1 | Serial data input |
| latch_pulse | input | 1 | One-cycle strobe that ends a command word |
| det_mode | input | 2 | Detection mode: 01 open, 10 short, 00/11 off |
| node_high | input | 16 | Comparator flags: 1 means the output node is above the threshold |
| drive_on | input | 16 | 1 means that output is currently driven on |
| ser_out | output | 1 | Serial data output, updated on falling-edge pulses |

## Verification
The bench covers each case where a status bit has to be zero, and each of them fails in its own way. If the mode decode used only one bit, mode `2'b11` would report faults. If the check ignored the output-on condition, a single enabled output would produce a fault word. Other cases target how commands and data flow through the shift word. A strobe carrying a near-miss word such as `0x003D` must leave that word intact; a design that captured on any strobe would replace it with status. The falling-edge retiming is also exercised. A rising pulse with no falling pulse must not move the output. In a two-device chain, a design that updated the output on rising pulses would lose or duplicate one bit at the boundary between the two devices.

// File: rtl/fault_status_pkg.sv
package fault_status_pkg;
  localparam int unsigned CH_COUNT = 16;
  localparam logic [15:0] READ_STATUS_CMD = 16'h003C;

  typedef enum logic [1:0] {
    DET_OFF_A = 2'b00,
    DET_OPEN  = 2'b01,
    DET_SHORT = 2'b10,
    DET_OFF_B = 2'b11
  } det_mode_e;

  // True when the mode field arms either check.
  function automatic logic mode_armed(input logic [1:0] mode);
    return (mode == DET_OPEN) || (mode == DET_SHORT);
  endfunction
endpackage

// File: rtl/fault_word_eval.sv
module fault_word_eval
  import fault_status_pkg::*;
#(
  parameter int unsigned CH = CH_COUNT
) (
  input  logic [1:0]    det_mode,
  input  logic [CH-1:0] node_high,
  input  logic [CH-1:0] drive_on,
  output logic          check_valid,
  output logic [CH-1:0] fault_word
);
  // The check is meaningful only when armed and every output is off.
  assign check_valid = mode_armed(det_mode) && (drive_on == '0);

  // Each channel is flagged as faulty when its node sits below the threshold.
  for (genvar n = 0; n < CH; n++) begin : g_ch
    assign fault_word[n] = check_valid & ~node_high[n];
  end
endmodule

// File: rtl/status_shifter.sv
module status_shifter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift,
  input  logic         sin,
  input  logic         fall,
  output logic [W-1:0] word_q,
  output logic         sout
);
  // Loading the status word has priority over shifting.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (load) begin
      word_q <= load_word;
    end else if (shift) begin
      word_q <= {word_q[W-2:0], sin};
    end
  end

  // The output is retimed onto the falling-edge pulse.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sout <= 1'b0;
    end else if (fall) begin
      sout <= word_q[W-1];
    end
  end
endmodule

// File: rtl/fault_status_capture.sv
module fault_status_capture
  import fault_status_pkg::*;
#(
  parameter int unsigned CH      = CH_COUNT,
  parameter logic [CH-1:0] RD_CMD = CH'(READ_STATUS_CMD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          ser_in,
  input  logic          latch_pulse,
  input  logic [1:0]    det_mode,
  input  logic [CH-1:0] node_high,
  input  logic [CH-1:0] drive_on,
  output logic          ser_out
);
  logic [CH-1:0] shreg_q;
  logic [CH-1:0] status_word;
  logic          check_valid;
  logic          capture_fire;

  // A strobe fires a capture only when the read-status command is resident.
  assign capture_fire = latch_pulse && (shreg_q == RD_CMD);

  fault_word_eval #(.CH(CH)) u_eval (
    .det_mode   (det_mode),
    .node_high  (node_high),
    .drive_on   (drive_on),
    .check_valid(check_valid),
    .fault_word (status_word)
  );

  status_shifter #(.W(CH)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (capture_fire),
    .load_word(status_word),
    .shift    (sclk_rise),
    .sin      (ser_in),
    .fall     (sclk_fall),
    .word_q   (shreg_q),
    .sout     (ser_out)
  );
endmodule

// File: rtl/fault_status_capture_chk.sv
module fault_status_capture_chk #(
  parameter int unsigned CH = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sclk_rise,
  input logic          sclk_fall,
  input logic          ser_in,
  input logic          latch_pulse,
  input logic [1:0]    det_mode,
  input logic [CH-1:0] node_high,
  input logic [CH-1:0] drive_on,
  input logic          ser_out,
  input logic [CH-1:0] shreg_q,
  input logic          capture_fire
);
  // R2
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !capture_fire) |=> shreg_q == {$past(shreg_q[CH-2:0]), $past(ser_in)});

  // R3
  sout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(ser_out));

  // R3
  sout_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_fall |=> ser_out == $past(shreg_q[CH-1]));

  // R5 R6
  armed_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_fire && (det_mode == 2'b01 || det_mode == 2'b10) && drive_on == '0)
      |=> shreg_q == ~$past(node_high));

  // R7
  mode_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_fire && (det_mode == 2'b00 || det_mode == 2'b11)) |=> shreg_q == '0);

  // R8
  drive_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_fire && drive_on != '0) |=> shreg_q == '0);

  // R9
  other_word_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_pulse && !capture_fire && !sclk_rise) |=> $stable(shreg_q));
endmodule

bind fault_status_capture fault_status_capture_chk #(.CH(CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sclk_rise   (sclk_rise),
  .sclk_fall   (sclk_fall),
  .ser_in      (ser_in),
  .latch_pulse (latch_pulse),
  .det_mode    (det_mode),
  .node_high   (node_high),
  .drive_on    (drive_on),
  .ser_out     (ser_out),
  .shreg_q     (shreg_q),
  .capture_fire(capture_fire)
);

// File: tb/fault_status_capture_test.sv
module fault_status_capture_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        sclk_rise, sclk_fall, din, latch_pulse;
  logic [1:0]  mode_a, mode_b;
  logic [15:0] high_a, high_b, on_a, on_b;
  logic        dout_a, dout_b;

  fault_status_capture uut (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .ser_in(din), .latch_pulse(latch_pulse), .det_mode(mode_a),
    .node_high(high_a), .drive_on(on_a), .ser_out(dout_a));

  fault_status_capture uut2 (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .ser_in(dout_a), .latch_pulse(latch_pulse), .det_mode(mode_b),
    .node_high(high_b), .drive_on(on_b), .ser_out(dout_b));

  int    n_total = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  bit    exp_q[$];
  string tag_q[$];
  bit    mon_far;  // 1 selects the far end of the chain
  event  smp;

  function automatic void check(string req, logic act, logic exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endfunction

  // Monitor: pops one expected bit per sample event.
  always @(smp) begin
    if (exp_q.size() == 0) begin
      n_total++; n_fail++;
      $display("FAIL scoreboard actual=unexpected-sample expected=empty-queue");
    end else begin
      check(tag_q.pop_front(), mon_far ? dout_b : dout_a, exp_q.pop_front());
    end
  end

  task automatic push_word(logic [15:0] w, string req);
    for (int i = 15; i >= 0; i--) begin
      exp_q.push_back(w[i]);
      tag_q.push_back(req);
    end
  endtask

  task automatic pulse_rise();
    sclk_rise = 1'b1; @(negedge clk); sclk_rise = 1'b0;
  endtask
  task automatic pulse_fall();
    sclk_fall = 1'b1; @(negedge clk); sclk_fall = 1'b0;
  endtask
  task automatic strobe();
    latch_pulse = 1'b1; @(negedge clk); latch_pulse = 1'b0; @(negedge clk);
  endtask

  task automatic send_word(logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      din = w[i];
      pulse_rise();
      pulse_fall();
    end
    din = 1'b0;
  endtask

  // Each bit: falling pulse presents the bit, sample, then a rising pulse shifts.
  task automatic read_bits(int n);
    for (int i = 0; i < n; i++) begin
      pulse_fall();
      -> smp;
      @(negedge clk);
      pulse_rise();
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; sclk_rise = 0; sclk_fall = 0; din = 0; latch_pulse = 0;
    mode_a = 2'b00; mode_b = 2'b00; high_a = '1; high_b = '1; on_a = '0; on_b = '0;
    mon_far = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1", dout_a, 1'b0);
    push_word(16'h0000, "R1");
    read_bits(16);

    // R2 and R3: plain shifting and falling-edge retiming
    send_word(16'hA5C3);
    check("R3", dout_a, 1'b1);
    pulse_rise();
    @(negedge clk);
    check("R3", dout_a, 1'b1);  // rising pulse alone must not move the output
    push_word({1'b0, 15'h25C3} << 1, "R2");
    void'(exp_q.pop_back()); void'(tag_q.pop_back());
    read_bits(15);

    // R4 R5: open check, all outputs off
    mode_a = 2'b01; on_a = '0; high_a = 16'h0F35;
    send_word(16'h003C); strobe();
    push_word(16'hF0CA, "R5");
    read_bits(16);

    // R6: short check, a single fault at output 0
    mode_a = 2'b10; high_a = 16'hFFFE;
    send_word(16'h003C); strobe();
    push_word(16'h0001, "R6");
    read_bits(16);

    // R7: both disabled codes give zeros
    mode_a = 2'b00; high_a = 16'h0000;
    send_word(16'h003C); strobe();
    push_word(16'h0000, "R7");
    read_bits(16);
    mode_a = 2'b11;
    send_word(16'h003C); strobe();
    push_word(16'h0000, "R7");
    read_bits(16);

    // R8: one output on blanks the word
    mode_a = 2'b01; on_a = 16'h0100;
    send_word(16'h003C); strobe();
    push_word(16'h0000, "R8");
    read_bits(16);
    on_a = '0;

    // R9: near-miss word survives the strobe
    send_word(16'h003D); strobe();
    push_word(16'h003D, "R9");
    read_bits(16);

    // R4 R10: two-device chain, far device first
    mode_a = 2'b01; high_a = 16'h1234;
    mode_b = 2'b10; high_b = 16'h00FF;
    send_word(16'h003C); send_word(16'h003C); strobe();
    mon_far = 1;
    push_word(16'hFF00, "R10");
    push_word(16'hEDCB, "R10");
    read_bits(32);

    @(negedge clk);
    if (exp_q.size() != 0) begin
      n_total++; n_fail++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", exp_q.size());
    end
    done = 1;
    summary();
  end
endmodule